// File: doc/BRIEF.md
# Dual-Channel ADC Capture Buffer

This block takes two converter channels that are sampled at the same instant and stores them side by side in on-chip memory. Each channel arrives as a 14-bit two's-complement word plus an over-range flag, and all of it is clocked by the converter's data-ready clock. A microcontroller starts a capture over SPI. The block then enables the converter outputs and throws away the words that are still travelling through the converter pipeline. After that it stores a fixed number of sample pairs, disables the outputs again and signals completion. The microcontroller then polls a status byte and reads the buffer back as one long SPI stream.

Two clocks are involved. Capture runs on the data-ready clock, and the SPI slave runs on a faster system clock that oversamples the SPI lines. Two toggle flags cross between the domains, each through a pair of flip-flops: one carries the start request and one carries completion. Memory contents are served only while no capture is running.

Top module: `dual_adc_capture`

## Requirements
- R1: After reset, `adc_oe_n` is 1 (converter outputs disabled), `spi_miso` is 0, and the status byte reads 0x00.
- R2: Command 0x01 drives `adc_oe_n` to 0. It stays 0 for exactly SKIP+DEPTH data-ready cycles, where SKIP defaults to 17 and DEPTH defaults to 2048, and then returns to 1.
- R3: The data presented on the first SKIP data-ready edges after `adc_oe_n` falls are discarded. The next DEPTH sample pairs are stored, in arrival order.
- R4: Each stored word is 16 bits. Bit 15 is the channel tag (0 for channel A, 1 for channel B), bit 14 is that sample's over-range flag, and bits 13:0 hold the two's-complement sample.
- R5: The SPI interface is mode 0 with MSB first. After the 8-bit command 0x03, the block shifts out words in the order A0, B0, A1, B1, and so on up to index DEPTH-1.
- R6: After the 8-bit command 0x02, the block shifts out one status byte. Bit 0 is busy, bit 1 is done (a capture has finished since reset and none is running), and bit 2 is overflow (suppressed while busy). Bits 7:3 are 0.
- R7: The overflow bit is set exactly when some stored sample of the last capture had its over-range flag high. Flags raised during the discarded cycles do not count, and the bit is cleared when the next capture starts.
- R8: Command 0x01 received while busy is ignored: no second capture takes place.
- R9: Command 0x03 received while busy returns all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| adc_clk | input | 1 | Converter data-ready clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| adc_a_data | input | 14 | Channel A sample, two's complement |
| adc_b_data | input | 14 | Channel B sample, two's complement |
| adc_a_ovr | input | 1 | Channel A over-range flag |
| adc_b_ovr | input | 1 | Channel B over-range flag |
| adc_oe_n | output | 1 | Active-low output enable for both converter channels |
| sys_clk | input | 1 | System clock that oversamples SPI |
| spi_sck | input | 1 | SPI clock from the master |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the master |
| spi_miso | output | 1 | SPI data to the master |

## Verification
The assertions rely on three properties of the inputs:
- Each SPI clock phase lasts several system-clock cycles, so that every edge survives the two-flop synchronizer.
- Chip select is raised only between complete transactions.
- The converter data and flags change away from the data-ready rising edge.

The bench produces SCK from the system clock with five cycles per phase and drives the converter inputs on the falling edge of the data-ready clock. Its status polls and its commands issued while busy are timed to finish well inside one capture window. This keeps the check of R2's window length and the check of the status flags that rise only inside a transaction meaningful.

// File: rtl/dual_adc_capture.sv
module dual_adc_capture #(
  parameter int DEPTH = 2048,
  parameter int SKIP  = 17,
  parameter int DW    = 14
) (
  input  logic          adc_clk,
  input  logic          rst_n,
  input  logic [DW-1:0] adc_a_data,
  input  logic [DW-1:0] adc_b_data,
  input  logic          adc_a_ovr,
  input  logic          adc_b_ovr,
  output logic          adc_oe_n,
  input  logic          sys_clk,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(SKIP + 1);
  localparam int WW = DW + 2;

  typedef enum logic [1:0] {S_IDLE, S_SKIP, S_FILL} st_t;

  logic [2*WW-1:0] mem [DEPTH];

  st_t             st;
  logic [1:0]      arm_s;
  logic            srv, done_tgl, ovf;
  logic [SW-1:0]   skip_cnt;
  logic [AW-1:0]   waddr;

  logic            arm_tgl, armed, have_cmd, busy, cs_s;
  logic [2:0]      sck_q;
  logic [1:0]      cs_q, mosi_q, done_q;
  logic [3:0]      bcnt;
  logic [6:0]      rx;
  logic [7:0]      cmd, status;
  logic [AW:0]     ptr;
  logic [WW-1:0]   tx, load_word;
  logic [2*WW-1:0] rd_q;

  always_ff @(posedge adc_clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_s    <= '0;
      srv      <= 1'b0;
      done_tgl <= 1'b0;
      st       <= S_IDLE;
      skip_cnt <= '0;
      waddr    <= '0;
      ovf      <= 1'b0;
      adc_oe_n <= 1'b1;
    end else begin
      arm_s <= {arm_s[0], arm_tgl};
      case (st)
        S_IDLE:
          if (arm_s[1] != srv) begin
            srv      <= arm_s[1];
            st       <= S_SKIP;
            skip_cnt <= '0;
            ovf      <= 1'b0;
            adc_oe_n <= 1'b0;
          end
        S_SKIP:
          if (skip_cnt == SW'(SKIP - 1)) begin
            st    <= S_FILL;
            waddr <= '0;
          end else begin
            skip_cnt <= skip_cnt + 1'b1;
          end
        S_FILL: begin
          ovf   <= ovf | adc_a_ovr | adc_b_ovr;
          waddr <= waddr + 1'b1;
          if (waddr == AW'(DEPTH - 1)) begin
            st       <= S_IDLE;
            adc_oe_n <= 1'b1;
            done_tgl <= srv;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge adc_clk)
    if (st == S_FILL)
      mem[waddr] <= {1'b1, adc_b_ovr, adc_b_data, 1'b0, adc_a_ovr, adc_a_data};

  always_ff @(posedge sys_clk)
    rd_q <= mem[ptr[AW:1]];

  assign cs_s   = cs_q[1];
  assign busy   = arm_tgl ^ done_q[1];
  assign status = {5'b0, ovf & ~busy, armed & ~busy, busy};

  always_comb begin
    load_word = '0;
    if (cmd == 8'h03 && !busy)
      load_word = ptr[0] ? rd_q[2*WW-1:WW] : rd_q[WW-1:0];
    else if (cmd == 8'h02 && ptr == '0)
      load_word = {status, {(WW-8){1'b0}}};
  end

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= '0;
      cs_q     <= 2'b11;
      mosi_q   <= '0;
      done_q   <= '0;
      arm_tgl  <= 1'b0;
      armed    <= 1'b0;
      have_cmd <= 1'b0;
      bcnt     <= '0;
      rx       <= '0;
      cmd      <= '0;
      ptr      <= '0;
      tx       <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], spi_sck};
      cs_q   <= {cs_q[0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
      done_q <= {done_q[0], done_tgl};
      if (cs_s) begin
        have_cmd <= 1'b0;
        bcnt     <= '0;
        ptr      <= '0;
        tx       <= '0;
        cmd      <= '0;
      end else if (sck_q[1] && !sck_q[2]) begin
        rx   <= {rx[5:0], mosi_q[1]};
        bcnt <= bcnt + 1'b1;
        if (!have_cmd && bcnt == 4'd7) begin
          have_cmd <= 1'b1;
          bcnt     <= '0;
          cmd      <= {rx, mosi_q[1]};
          if ({rx, mosi_q[1]} == 8'h01 && !busy) begin
            arm_tgl <= ~arm_tgl;
            armed   <= 1'b1;
          end
        end
      end else if (!sck_q[1] && sck_q[2]) begin
        if (have_cmd && bcnt == 4'd0) begin
          tx  <= load_word;
          ptr <= ptr + 1'b1;
        end else begin
          tx <= {tx[WW-2:0], 1'b0};
        end
      end
    end
  end

  assign spi_miso = tx[WW-1];
endmodule

// File: rtl/dual_adc_capture_chk.sv
module dual_adc_capture_chk #(
  parameter int DEPTH = 2048,
  parameter int SKIP  = 17
) (
  input logic adc_clk,
  input logic sys_clk,
  input logic rst_n,
  input logic adc_oe_n,
  input logic ovf,
  input logic busy,
  input logic cs_s,
  input logic spi_miso
);
  localparam logic [31:0] WIN = 32'(SKIP + DEPTH);
  logic [31:0] low_cnt;

  always_ff @(posedge adc_clk or negedge rst_n)
    if (!rst_n) low_cnt <= '0;
    else        low_cnt <= adc_oe_n ? '0 : low_cnt + 1;

  a_r2_enable_window: assert property (@(posedge adc_clk) disable iff (!rst_n)
    $rose(adc_oe_n) |-> low_cnt == WIN);

  a_r7_ovf_clears_on_arm: assert property (@(posedge adc_clk) disable iff (!rst_n)
    $fell(ovf) |-> $fell(adc_oe_n));

  a_r6_busy_in_txn: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(busy) |-> !cs_s);

  a_r5_idle_miso_low: assert property (@(posedge sys_clk) disable iff (!rst_n)
    cs_s |=> !spi_miso);
endmodule

bind dual_adc_capture dual_adc_capture_chk #(.DEPTH(DEPTH), .SKIP(SKIP)) u_chk (
  .adc_clk(adc_clk), .sys_clk(sys_clk), .rst_n(rst_n), .adc_oe_n(adc_oe_n),
  .ovf(ovf), .busy(busy), .cs_s(cs_s), .spi_miso(spi_miso)
);

// File: tb/dual_adc_capture_tb.sv
module dual_adc_capture_tb;
  localparam int DEPTH = 64;
  localparam int SKIP  = 17;
  localparam int HALF  = 5;

  logic adc_clk = 1'b0, sys_clk = 1'b0, rst_n = 1'b0;
  logic [13:0] da = '0, db = '0;
  logic oa = 1'b0, ob = 1'b0;
  logic adc_oe_n, spi_miso;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;

  int checks = 0, errors = 0;
  int k = 0, kmax = 0, mode = 0, falls = 0;
  logic exp_ovf = 1'b0;
  logic [15:0] exp_a [DEPTH];
  logic [15:0] exp_b [DEPTH];
  logic rxb [4096];

  always #2  sys_clk = ~sys_clk;
  always #25 adc_clk = ~adc_clk;

  dual_adc_capture #(.DEPTH(DEPTH), .SKIP(SKIP)) u_dut (
    .adc_clk(adc_clk), .rst_n(rst_n), .adc_a_data(da), .adc_b_data(db),
    .adc_a_ovr(oa), .adc_b_ovr(ob), .adc_oe_n(adc_oe_n), .sys_clk(sys_clk),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always @(negedge adc_oe_n) falls++;

  always @(negedge adc_clk) begin
    if (adc_oe_n !== 1'b0) k = 0; else k = k + 1;
    da = 14'($urandom);
    db = 14'($urandom);
    case (mode)
      0: begin oa = ($urandom % 16) == 0; ob = ($urandom % 16) == 0; end
      1: begin oa = (k > 0 && k <= SKIP); ob = oa; end
      default: begin oa = 1'b0; ob = (k == SKIP + DEPTH); end
    endcase
    if (k > SKIP && k <= SKIP + DEPTH) begin
      exp_a[k-SKIP-1] = {1'b0, oa, da};
      exp_b[k-SKIP-1] = {1'b1, ob, db};
      exp_ovf = exp_ovf | oa | ob;
    end
    if (k > kmax) kmax = k;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] c, input int nbits);
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge sys_clk);
    for (int i = 0; i < 8 + nbits; i++) begin
      spi_mosi = (i < 8) ? c[7-i] : 1'b0;
      repeat (HALF) @(negedge sys_clk);
      if (i >= 8) rxb[i-8] = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge sys_clk);
      spi_sck = 1'b0;
    end
    repeat (HALF) @(negedge sys_clk);
    spi_cs_n = 1'b1;
    repeat (2*HALF) @(negedge sys_clk);
  endtask

  function automatic logic [15:0] word_at(input int w);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) r[15-b] = rxb[16*w + b];
    return r;
  endfunction

  function automatic logic [7:0] byte0();
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[7-b] = rxb[b];
    return r;
  endfunction

  task automatic run_capture(input int m, input bit busy_checks);
    logic [7:0] st;
    mode = m;
    exp_ovf = 1'b0;
    kmax = 0;
    xfer(8'h01, 0);
    if (busy_checks) begin
      xfer(8'h02, 8);
      chk("R6 busy status during capture", 32'(byte0()), 32'h01);
      xfer(8'h01, 0);
      xfer(8'h03, 32);
      chk("R9 read while busy word0", 32'(word_at(0)), 32'h0);
      chk("R9 read while busy word1", 32'(word_at(1)), 32'h0);
    end
    st = 8'h01;
    for (int p = 0; p < 200 && st[0]; p++) begin
      xfer(8'h02, 8);
      st = byte0();
    end
    chk("R2 enable window length", 32'(kmax), 32'(SKIP + DEPTH));
    chk("R6 R7 final status", 32'(st), {29'b0, exp_ovf, 2'b10});
    xfer(8'h03, 32*DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 R4 R5 channel A word", 32'(word_at(2*i)),   32'(exp_a[i]));
      chk("R3 R4 R5 channel B word", 32'(word_at(2*i+1)), 32'(exp_b[i]));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (20) @(negedge sys_clk);
    rst_n = 1'b1;
    repeat (10) @(negedge sys_clk);
    chk("R1 oe_n after reset", 32'(adc_oe_n), 32'h1);
    chk("R1 miso after reset", 32'(spi_miso), 32'h0);
    xfer(8'h02, 8);
    chk("R1 R6 status after reset", 32'(byte0()), 32'h0);
    run_capture(1, 1'b1);
    repeat (300) @(negedge sys_clk);
    chk("R8 one capture despite second arm", 32'(falls), 32'h1);
    run_capture(0, 1'b0);
    run_capture(2, 1'b0);
    run_capture(1, 1'b0);
    chk("R7 R8 capture count", 32'(falls), 32'h4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge sys_clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule